// File: doc/BRIEF.md
# Interrupt Acknowledge Bus Sequencer

This block runs the bus half of a processor's response to an external interrupt. When the core raises a start request, the sequencer runs two acknowledge bus cycles back to back, each four clock states long (T1, T2, T3, T4). It shows the acknowledge strobe and which of the two cycles is active. It holds a bus lock output across the pair so that no other master can take the bus between them.

During the second cycle the sequencer reads an 8-bit interrupt type from the external interrupt controller off the data bus. It turns that type into the byte address of a 4-byte entry in a 256-entry vector table at the bottom of memory. It returns the address to the core with a one-clock done strobe. A local bus hold request that arrives while the sequence runs is deferred and granted only once the sequence has finished.

Top module: `intack_seq`

## Requirements
- R1: After a synchronous active-low reset, `busy_o`, `ack_o`, `ack_sel_o`, `lock_o`, `hold_gnt_o` and `done_o` are 0 and `vec_addr_o` is 0.
- R2: A start request seen at a clock edge while the block is idle and the bus is not granted makes the next clock state T1 of the first acknowledge cycle. `busy_o` is then high for exactly 8 consecutive clocks.
- R3: The 8 busy clocks are T1..T4 of cycle 0 followed at once by T1..T4 of cycle 1. `ack_o` is 1 in T2 and T3 and 0 in T1 and T4. `ack_sel_o` is 0 during cycle 0 and 1 during cycle 1.
- R4: `lock_o` is 1 in exactly five clocks: T2, T3 and T4 of cycle 0, and T1 and T2 of cycle 1. It is 0 at all other times.
- R5: The type byte is the value on `data_i` during T3 of cycle 1. It is taken at the clock edge that ends that state. `data_i` in every other clock has no effect on the result.
- R6: `done_o` is high for exactly one clock, the clock right after T4 of cycle 1. In that clock `vec_addr_o` equals the type byte times four: {type, 2'b00}, 10 bits, range 0x000..0x3FC. `vec_addr_o` keeps that value until the next done.
- R7: Start requests made while `busy_o` is 1 are ignored. No second sequence begins, and the block is idle in the clock after done.
- R8: `hold_gnt_o` is 0 during all 8 sequence clocks whatever `hold_req_i` does. If `hold_req_i` is 1 at the edge ending T4 of cycle 1, `hold_gnt_o` is 1 in the done clock.
- R9: While idle, `hold_gnt_o` follows `hold_req_i` one clock later. While `hold_gnt_o` is 1, start requests are ignored.
- R10: If start and hold requests arrive at the same idle edge while not granted, the start wins: the sequence begins and the grant is deferred as in R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Interrupt response request from the core |
| data_i | input | 8 | Data bus carrying the interrupt type byte |
| hold_req_i | input | 1 | Local bus hold request |
| busy_o | output | 1 | Acknowledge sequence in progress |
| ack_o | output | 1 | Acknowledge strobe, high in T2 and T3 |
| ack_sel_o | output | 1 | Which acknowledge cycle is running (0 first, 1 second) |
| lock_o | output | 1 | Bus lock spanning the acknowledge pair |
| hold_gnt_o | output | 1 | Local bus hold grant |
| done_o | output | 1 | One-clock strobe: vector address valid |
| vec_addr_o | output | 10 | Vector table byte address, type times four |

## Verification
Some rules are checked by assertions on every clock:
- the busy window has no gap and ends in a done;
- the acknowledge strobe appears only while busy;
- the lock rises only with the first cycle's strobe and falls only after the second cycle's strobe;
- done is a single-clock pulse;
- no grant appears inside the sequence.

Other behaviour can only be shown by the bench's scenarios:
- the exact state-by-state shape of the strobe, lock and cycle select;
- the type being taken only from T3 of the second cycle, with other data ignored;
- the address value matching the type;
- start being ignored while busy or while the bus is granted;
- start winning a tie against hold.

// File: rtl/intack_pkg.sv
// Package: shared parameters and the bus-state type of the interrupt
// acknowledge sequencer. Assumes four clock states per bus cycle.
package intack_pkg;
    parameter int TYPE_W     = 8;  // width of the interrupt type byte
    parameter int ENTRY_LOG2 = 2;  // log2 of bytes per vector entry
    parameter int ACK_CYCLES = 2;  // acknowledge cycles per response
    localparam int CYC_W  = (ACK_CYCLES > 1) ? $clog2(ACK_CYCLES) : 1;
    localparam int ADDR_W = TYPE_W + ENTRY_LOG2;

    typedef enum logic [1:0] {
        ST_T1 = 2'd0,
        ST_T2 = 2'd1,
        ST_T3 = 2'd2,
        ST_T4 = 2'd3
    } tstate_e;
endpackage

// File: rtl/intack_seq_fsm.sv
// Module: state counter of the acknowledge sequence. It walks T1..T4 for
// each of ACK_CYCLES bus cycles with no idle state between them.
// Assumes accept_i is only raised while idle.
module intack_seq_fsm
    import intack_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept_i,
    output logic             busy_o,
    output logic [CYC_W-1:0] cyc_o,
    output tstate_e          tst_o,
    output logic             last_o
);
    localparam logic [CYC_W-1:0] LAST_CYC = CYC_W'(ACK_CYCLES - 1);

    logic             busy_q;
    logic [CYC_W-1:0] cyc_q;
    tstate_e          tst_q;

    // Advance through bus states; leave busy after the last T4.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cyc_q  <= '0;
            tst_q  <= ST_T1;
        end else if (!busy_q) begin
            if (accept_i) begin
                busy_q <= 1'b1;
                cyc_q  <= '0;
                tst_q  <= ST_T1;
            end
        end else if (tst_q == ST_T4) begin
            tst_q <= ST_T1;
            if (cyc_q == LAST_CYC) begin
                busy_q <= 1'b0;
                cyc_q  <= '0;
            end else begin
                cyc_q <= cyc_q + 1'b1;
            end
        end else begin
            tst_q <= tstate_e'(tst_q + 2'd1);
        end
    end

    // Flag the final state of the final cycle.
    always_comb last_o = busy_q && (cyc_q == LAST_CYC) && (tst_q == ST_T4);

    assign busy_o = busy_q;
    assign cyc_o  = cyc_q;
    assign tst_o  = tst_q;

    // R3: the sequence keeps running until its final state.
    p_no_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q && !last_o |=> busy_q);
    // R7: a running sequence is never restarted from its first state.
    p_no_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q && !last_o |=> !(cyc_q == '0 && tst_q == ST_T1));
endmodule

// File: rtl/intack_bus_ctl.sv
// Module: decodes the bus state into the acknowledge strobe, cycle select,
// lock span and type-capture enable. Purely combinational from the
// registered state, so the outputs do not depend on inputs.
module intack_bus_ctl
    import intack_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             busy_i,
    input  logic [CYC_W-1:0] cyc_i,
    input  tstate_e          tst_i,
    output logic             ack_o,
    output logic             ack_sel_o,
    output logic             lock_o,
    output logic             cap_en_o
);
    localparam logic [CYC_W-1:0] LAST_CYC = CYC_W'(ACK_CYCLES - 1);

    logic first_c, last_c, mid_c;

    // Classify the running cycle.
    always_comb begin
        first_c = (cyc_i == '0);
        last_c  = (cyc_i == LAST_CYC);
        mid_c   = !first_c && !last_c;
    end

    // Strobe, lock window and capture point.
    always_comb begin
        ack_o     = busy_i && (tst_i == ST_T2 || tst_i == ST_T3);
        ack_sel_o = busy_i && !first_c;
        lock_o    = busy_i && ((first_c && tst_i != ST_T1) || mid_c ||
                               (last_c && !first_c &&
                                (tst_i == ST_T1 || tst_i == ST_T2)));
        cap_en_o  = busy_i && last_c && (tst_i == ST_T3);
    end

    // R4: lock rises together with the first cycle's strobe.
    p_lock_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_o) |-> ack_o && !ack_sel_o);
    // R4: lock drops only after the last cycle's strobe has started.
    p_lock_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lock_o) |-> $past(ack_o) && $past(ack_sel_o));
    // R3: no acknowledge strobe outside a sequence.
    p_ack_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> busy_i);
endmodule

// File: rtl/intack_type_cap.sv
// Module: captures the type byte at the end of T3 of the last cycle and
// issues the scaled table address with a one-clock done strobe.
// Assumes cap_en_i precedes last_i by one clock.
module intack_type_cap
    import intack_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en_i,
    input  logic              last_i,
    input  logic [TYPE_W-1:0] data_i,
    output logic              done_o,
    output logic [ADDR_W-1:0] addr_o
);
    logic [TYPE_W-1:0] type_q;
    logic              done_q;
    logic [ADDR_W-1:0] addr_q;

    // Hold the type byte from the data bus.
    always_ff @(posedge clk) begin
        if (!rst_n)        type_q <= '0;
        else if (cap_en_i) type_q <= data_i;
    end

    // Publish the entry address and pulse done after the last state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            addr_q <= '0;
        end else begin
            done_q <= last_i;
            if (last_i) addr_q <= {type_q, {ENTRY_LOG2{1'b0}}};
        end
    end

    assign done_o = done_q;
    assign addr_o = addr_q;

    // R6: done lasts one clock.
    p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);
    // R6: the address only moves together with done.
    p_addr_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !done_q |-> $stable(addr_q));
endmodule

// File: rtl/intack_hold_arb.sv
// Module: local bus hold grant. Follows the request one clock late while
// idle, and defers it across the whole acknowledge sequence.
// Assumes accept_i is start already qualified by idle and not granted.
module intack_hold_arb (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_req_i,
    input  logic busy_i,
    input  logic last_i,
    input  logic accept_i,
    output logic gnt_o
);
    logic gnt_q;

    // Register the grant; block it inside the sequence and on a start.
    always_ff @(posedge clk) begin
        if (!rst_n)                  gnt_q <= 1'b0;
        else if (busy_i && !last_i)  gnt_q <= 1'b0;
        else if (accept_i)           gnt_q <= 1'b0;
        else                         gnt_q <= hold_req_i;
    end

    assign gnt_o = gnt_q;

    // R8: no grant in a clock that follows a non-final sequence state.
    p_gnt_deferred_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i && !last_i |=> !gnt_q);
    // R10: a starting sequence never sees a grant next clock.
    p_start_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        accept_i |=> !gnt_q);
endmodule

// File: rtl/intack_seq.sv
// Module: top of the interrupt acknowledge bus sequencer. It ties the state
// counter, bus decode, type capture and hold arbiter together.
// Assumes start_i is a level the core holds until it sees busy.
module intack_seq
    import intack_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [TYPE_W-1:0] data_i,
    input  logic              hold_req_i,
    output logic              busy_o,
    output logic              ack_o,
    output logic              ack_sel_o,
    output logic              lock_o,
    output logic              hold_gnt_o,
    output logic              done_o,
    output logic [ADDR_W-1:0] vec_addr_o
);
    logic             busy, last, accept, cap_en, gnt;
    logic [CYC_W-1:0] cyc;
    tstate_e          tst;

    // Take a start only when idle and the bus is not given away.
    always_comb accept = start_i && !busy && !gnt;

    intack_seq_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .accept_i(accept),
        .busy_o  (busy),
        .cyc_o   (cyc),
        .tst_o   (tst),
        .last_o  (last)
    );

    intack_bus_ctl u_bus (
        .clk      (clk),
        .rst_n    (rst_n),
        .busy_i   (busy),
        .cyc_i    (cyc),
        .tst_i    (tst),
        .ack_o    (ack_o),
        .ack_sel_o(ack_sel_o),
        .lock_o   (lock_o),
        .cap_en_o (cap_en)
    );

    intack_type_cap u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap_en_i(cap_en),
        .last_i  (last),
        .data_i  (data_i),
        .done_o  (done_o),
        .addr_o  (vec_addr_o)
    );

    intack_hold_arb u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold_req_i(hold_req_i),
        .busy_i    (busy),
        .last_i    (last),
        .accept_i  (accept),
        .gnt_o     (gnt)
    );

    assign busy_o     = busy;
    assign hold_gnt_o = gnt;

    // R6: done follows a busy clock.
    p_done_after_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(busy_o));
    // R2: leaving busy always yields a done.
    p_busy_end_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);
    // R8: grant and busy are never both high.
    p_gnt_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(hold_gnt_o && busy_o));
endmodule

// File: tb/test_intack_seq.sv
module test_intack_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [7:0] data_i = 8'h00;
    logic       hold_req_i = 1'b0;
    logic       busy_o, ack_o, ack_sel_o, lock_o, hold_gnt_o, done_o;
    logic [9:0] vec_addr_o;

    int errors = 0;
    int checks = 0;
    logic [9:0] exp_q[$];

    always #4 clk = ~clk;  // 125 MHz

    intack_seq i_intack_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .data_i(data_i),
        .hold_req_i(hold_req_i), .busy_o(busy_o), .ack_o(ack_o),
        .ack_sel_o(ack_sel_o), .lock_o(lock_o), .hold_gnt_o(hold_gnt_o),
        .done_o(done_o), .vec_addr_o(vec_addr_o)
    );

    task automatic chk(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Monitor: compares each done against the scoreboard queue (R6).
    always @(negedge clk) begin
        if (rst_n && done_o) begin
            if (exp_q.size() == 0) chk("R6 unexpected done", 1, 0);
            else chk("R6 vec_addr", {22'd0, vec_addr_o}, {22'd0, exp_q.pop_front()});
        end
    end

    // Driver: one full acknowledge sequence. Pushes the expected address.
    // keep_start holds start high while busy (R7); hold is the hold_req
    // level driven throughout (R8).
    task automatic run_seq(input logic [7:0] ty, input bit keep_start,
                           input bit hold);
        @(negedge clk);
        start_i = 1'b1;
        hold_req_i = hold;
        exp_q.push_back({ty, 2'b00});
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            chk("R2 busy", busy_o, 1);
            chk("R3 ack", ack_o, ((i % 4) == 1 || (i % 4) == 2));
            chk("R3 ack_sel", ack_sel_o, (i >= 4));
            chk("R4 lock", lock_o, (i >= 1 && i <= 5));
            chk("R8 gnt deferred", hold_gnt_o, 0);
            start_i = keep_start && (i < 7);
            // R5: only data during T3 of cycle 1 (step 6) counts.
            data_i = (i == 6) ? ty : ~ty;
        end
        @(negedge clk);
        chk("R6 done", done_o, 1);
        chk("R7 idle after done", busy_o, 0);
        chk("R8 gnt in done clock", hold_gnt_o, hold);
        chk("R4 lock off", lock_o, 0);
        hold_req_i = 1'b0;
        @(negedge clk);
        chk("R6 done single", done_o, 0);
        chk("R6 addr held", vec_addr_o, {ty, 2'b00});
        chk("R7 no second seq", busy_o, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state.
        chk("R1 busy", busy_o, 0);
        chk("R1 ack", ack_o, 0);
        chk("R1 ack_sel", ack_sel_o, 0);
        chk("R1 lock", lock_o, 0);
        chk("R1 gnt", hold_gnt_o, 0);
        chk("R1 done", done_o, 0);
        chk("R1 addr", vec_addr_o, 0);
        rst_n = 1'b1;

        run_seq(8'h08, 1'b0, 1'b0);
        run_seq(8'hFF, 1'b1, 1'b0);  // R7 start held while busy
        run_seq(8'h00, 1'b0, 1'b0);
        run_seq(8'hA5, 1'b0, 1'b1);  // R10 tie: start wins; R8 deferred grant

        // R9: idle hold follows one clock late; start ignored while granted.
        @(negedge clk);
        hold_req_i = 1'b1;
        @(negedge clk);
        chk("R9 grant", hold_gnt_o, 1);
        start_i = 1'b1;
        @(negedge clk);
        chk("R9 start ignored", busy_o, 0);
        chk("R9 grant kept", hold_gnt_o, 1);
        start_i = 1'b0;
        hold_req_i = 1'b0;
        @(negedge clk);
        chk("R9 grant released", hold_gnt_o, 0);
        chk("R9 still idle", busy_o, 0);

        run_seq(8'h3C, 1'b0, 1'b0);
        repeat (2) @(negedge clk);
        chk("R6 all done seen", exp_q.size(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #100000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule